// File: doc/BRIEF.md
# Channel-2 Voltage Code Register and Ramp Controller

This block holds the control registers of a three-channel step-down regulator and drives the voltage code of its one programmable channel. A register port with a valid/ready request stream and a valid/ready read-response stream sits behind a serial slave, which is not part of this block. Software writes a 7-bit target code into a staging register. That value has no effect on the output until software sets the GO bit in the channel-2 command register. The active code then walks toward the target by one code per `step_tick` pulse. Each code step is 10 mV: code 0 is 0.68 V and code 127 is 1.95 V.

Each channel has a command register with an enable bit and a bit that forces continuous fixed-frequency operation in place of pulse skipping. A read-only status register reports one power-good flag per channel and the ramp-busy flag. When the serial pins are found floating or grounded (`bus_off`), the block drops all register traffic. Each channel then follows its own enable pin, and channel 2 falls back to its external-divider voltage.

Request rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Only reads produce a response. `req_ready` is low while a response is waiting and `rsp_ready` is low. A response keeps `rsp_valid` and `rsp_rdata` steady until it is taken.

Top module: `vreg_ctl`

## Requirements
- R1: After reset, `vid_code` is 32, the staging register reads 32, `ramp_busy` is 0, all command registers read 0x00, and `ch_en`, `ccm_mode` and `ext_fb` are 0.
- R2: A write to address 0x01 stores bits 6:0 as the staged code, which reads back from 0x01. `vid_code` does not change.
- R3: A write to 0x04 with bit 7 (GO) set loads the staged code as the target and raises `ramp_busy` from the next cycle. Each clock edge that has `step_tick` high while busy moves `vid_code` one code toward the target, upward or downward.
- R4: `ramp_busy` and the GO bit (bit 7 of a 0x04 read) fall one cycle after `vid_code` equals the target. This includes a GO whose target equals the active code. Writing bit 7 as 0 does not stop a ramp.
- R5: A write to 0x01 during a ramp changes only the staged code, and the ramp continues toward the old target. A new GO retargets the ramp from the current `vid_code`.
- R6: The command registers for channels 1, 2 and 3 sit at 0x03, 0x04 and 0x05. Bit 0 is the enable and drives `ch_en[i]`. Bit 1 forces continuous mode and drives `ccm_mode[i]`. Both bits read back.
- R7: Address 0x06 reads `pg_in` in bits 2:0 and `ramp_busy` in bit 3, with all other bits 0. Writes to 0x06 are ignored.
- R8: Addresses other than 0x01 and 0x03 to 0x06 read 0x00, and writes to them change no register or output.
- R9: While `bus_off` is high, `ch_en` equals `en_pin`, `ccm_mode` is 0, `ext_fb` is 1, reads return 0x00, and writes are ignored. The register contents are kept for when the bus returns.
- R10: While a read response waits with `rsp_ready` low, `req_ready` is low and `rsp_valid` and `rsp_rdata` hold.
- R11: The ramp reaches codes 0 and 127 and never wraps past either end. `vid_code` changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_off | input | 1 | Serial pins found floating or grounded |
| en_pin | input | 3 | Per-channel enable pins, used while bus_off |
| pg_in | input | 3 | Per-channel power-good flags |
| step_tick | input | 1 | Ramp step strobe |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 8 | Read data |
| vid_code | output | 7 | Active channel-2 voltage code |
| ramp_busy | output | 1 | Ramp in progress |
| ch_en | output | 3 | Channel enables |
| ccm_mode | output | 3 | Continuous-mode force per channel |
| ext_fb | output | 1 | Channel 2 uses the external divider |

## Verification
A wrong target or a wrong step direction shows on `vid_code` at the first `step_tick` after GO, and from there each tick takes the code further from the expected value. A busy flag that stays up or drops early shows on `ramp_busy` and in the GO bit one cycle after the code reaches the target. A corrupted staging or command register shows on the next read of that address, or at once on `ch_en` and `ccm_mode`. A fault in the `bus_off` gating shows within the same cycle on the enable and mode pins.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
  localparam logic [7:0] VID_ADDR  = 8'h01;
  localparam logic [7:0] CMD_BASE  = 8'h03;
  localparam logic [7:0] STAT_ADDR = 8'h06;
  localparam int EN_BIT  = 0;
  localparam int CCM_BIT = 1;
  localparam int GO_BIT  = 7;

  typedef struct packed {
    logic ccm;
    logic en;
  } chan_cmd_t;
endpackage

// File: rtl/vreg_regs.sv
module vreg_regs
  import vreg_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int VID_W   = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int VID_CH  = 1,
  parameter int VID_RST = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_off,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [NCH-1:0]    pg_in,
  input  logic              busy,
  output logic [VID_W-1:0]  pend_code,
  output logic              go_set,
  output chan_cmd_t [NCH-1:0] cmd
);
  localparam int PAD_W = DATA_W - VID_W;

  logic acc, wr;
  logic [NCH-1:0] cmd_hit;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc = req_valid && req_ready;
  assign wr  = acc && req_write && !bus_off;

  always_ff @(posedge clk) begin
    if (rst) pend_code <= VID_W'(VID_RST);
    else if (wr && req_addr == ADDR_W'(VID_ADDR)) pend_code <= req_wdata[VID_W-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmd
    assign cmd_hit[i] = (req_addr == ADDR_W'(CMD_BASE + 8'(i)));
    always_ff @(posedge clk) begin
      if (rst) cmd[i] <= '0;
      else if (wr && cmd_hit[i]) begin
        cmd[i].en  <= req_wdata[EN_BIT];
        cmd[i].ccm <= req_wdata[CCM_BIT];
      end
    end
  end

  assign go_set = wr && cmd_hit[VID_CH] && req_wdata[GO_BIT];

  always_comb begin
    rd_mux = '0;
    if (req_addr == ADDR_W'(VID_ADDR)) rd_mux = {{PAD_W{1'b0}}, pend_code};
    if (req_addr == ADDR_W'(STAT_ADDR)) begin
      rd_mux[NCH-1:0] = pg_in;
      rd_mux[NCH]     = busy;
    end
    for (int i = 0; i < NCH; i++) begin
      if (cmd_hit[i]) begin
        rd_mux[EN_BIT]  = cmd[i].en;
        rd_mux[CCM_BIT] = cmd[i].ccm;
        if (i == VID_CH) rd_mux[GO_BIT] = busy;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= bus_off ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vreg_ramp.sv
module vreg_ramp #(
  parameter int VID_W   = 7,
  parameter int VID_RST = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_tick,
  input  logic             go_set,
  input  logic [VID_W-1:0] pend_code,
  output logic [VID_W-1:0] vid_code,
  output logic             busy
);
  logic [VID_W-1:0] tgt;
  logic at_tgt;

  assign at_tgt = (vid_code == tgt);

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_code <= VID_W'(VID_RST);
      tgt      <= VID_W'(VID_RST);
      busy     <= 1'b0;
    end else begin
      if (busy && step_tick && !at_tgt)
        vid_code <= (vid_code < tgt) ? vid_code + 1'b1 : vid_code - 1'b1;
      if (go_set) begin
        tgt  <= pend_code;
        busy <= 1'b1;
      end else if (busy && at_tgt) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vreg_chan_out.sv
module vreg_chan_out
  import vreg_pkg::*;
(
  input  logic      bus_off,
  input  logic      en_pin,
  input  chan_cmd_t cmd,
  output logic      ch_en,
  output logic      ccm_mode
);
  assign ch_en    = bus_off ? en_pin : cmd.en;
  assign ccm_mode = !bus_off && cmd.ccm;
endmodule

// File: rtl/vreg_ctl.sv
module vreg_ctl
  import vreg_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int VID_W   = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int VID_CH  = 1,
  parameter int VID_RST = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_off,
  input  logic [NCH-1:0]    en_pin,
  input  logic [NCH-1:0]    pg_in,
  input  logic              step_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [VID_W-1:0]  vid_code,
  output logic              ramp_busy,
  output logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    ccm_mode,
  output logic              ext_fb
);
  logic [VID_W-1:0] pend_code;
  logic go_set;
  chan_cmd_t [NCH-1:0] cmd;

  vreg_regs #(.NCH(NCH), .VID_W(VID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
              .VID_CH(VID_CH), .VID_RST(VID_RST)) u_regs (
    .clk(clk), .rst(rst), .bus_off(bus_off),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pg_in(pg_in), .busy(ramp_busy), .pend_code(pend_code),
    .go_set(go_set), .cmd(cmd)
  );

  vreg_ramp #(.VID_W(VID_W), .VID_RST(VID_RST)) u_ramp (
    .clk(clk), .rst(rst), .step_tick(step_tick), .go_set(go_set),
    .pend_code(pend_code), .vid_code(vid_code), .busy(ramp_busy)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    vreg_chan_out u_out (
      .bus_off(bus_off), .en_pin(en_pin[i]), .cmd(cmd[i]),
      .ch_en(ch_en[i]), .ccm_mode(ccm_mode[i])
    );
  end

  assign ext_fb = bus_off;
endmodule

// File: rtl/vreg_ctl_chk.sv
module vreg_ctl_chk #(
  parameter int NCH    = 3,
  parameter int VID_W  = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_off,
  input logic [NCH-1:0]    en_pin,
  input logic              step_tick,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [VID_W-1:0]  vid_code,
  input logic              ramp_busy,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    ccm_mode,
  input logic              ext_fb
);
  // R3
  code_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(vid_code) |-> ($past(step_tick) && $past(ramp_busy)));

  // R11
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, vid_code} == {1'b0, $past(vid_code)}) ||
    ({1'b0, vid_code} == {1'b0, $past(vid_code)} + 1'b1) ||
    ({1'b0, vid_code} + 1'b1 == {1'b0, $past(vid_code)}));

  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ramp_busy) |-> $stable(vid_code));

  // R9
  bus_off_pins_chk: assert property (@(posedge clk) disable iff (rst)
    bus_off |-> (ch_en == en_pin && ccm_mode == '0 && ext_fb));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10
  req_block_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind vreg_ctl vreg_ctl_chk #(.NCH(NCH), .VID_W(VID_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_off(bus_off), .en_pin(en_pin),
  .step_tick(step_tick), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .vid_code(vid_code),
  .ramp_busy(ramp_busy), .ch_en(ch_en), .ccm_mode(ccm_mode), .ext_fb(ext_fb)
);

// File: tb/vreg_ctl_bench.sv
module vreg_ctl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_off = 1'b0;
  logic [2:0] en_pin = '0;
  logic [2:0] pg_in = '0;
  logic step_tick = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;
  logic [6:0] vid_code;
  logic ramp_busy;
  logic [2:0] ch_en, ccm_mode;
  logic ext_fb;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  vreg_ctl u_vreg_ctl (
    .clk(clk), .rst(rst), .bus_off(bus_off), .en_pin(en_pin), .pg_in(pg_in),
    .step_tick(step_tick), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .vid_code(vid_code), .ramp_busy(ramp_busy), .ch_en(ch_en),
    .ccm_mode(ccm_mode), .ext_fb(ext_fb)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(bit w, logic [7:0] a, logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    send(1'b1, a, d);
  endtask

  task automatic rd(logic [7:0] a, int exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    send(1'b0, a, 8'h00);
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      step_tick = 1'b1;
      @(negedge clk);
    end
    step_tick = 1'b0;
  endtask

  // monitor: pops the scoreboard when a response is taken
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL R10: actual=unexpected response expected=none");
      end else begin
        check(tag_q.pop_front(), int'(rsp_rdata), exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 vid", vid_code, 32);
    check("R1 busy", ramp_busy, 0);
    check("R1 en", ch_en, 0);
    check("R1 ccm", ccm_mode, 0);
    check("R1 extfb", ext_fb, 0);
    rd(8'h01, 32, "R1 stage");
    rd(8'h04, 0, "R1 cmd2");

    // R2 staging only
    wr(8'h01, 8'd35);
    tick(2);
    check("R2 vid held", vid_code, 32);
    rd(8'h01, 35, "R2 stage");

    // R3 upward ramp
    wr(8'h04, 8'h81);
    check("R3 busy", ramp_busy, 1);
    check("R6 en2", ch_en, 3'b010);
    tick(3);
    check("R3 up", vid_code, 35);
    check("R4 busy hold", ramp_busy, 1);
    @(negedge clk);
    check("R4 busy drop", ramp_busy, 0);
    rd(8'h04, 8'h01, "R4 go clear");

    // R3 downward, R5 retarget
    wr(8'h01, 8'd30);
    wr(8'h04, 8'h81);
    tick(2);
    check("R3 down", vid_code, 33);
    wr(8'h01, 8'd40);
    rd(8'h04, 8'h81, "R4 go set");
    tick(1);
    check("R5 old target", vid_code, 32);
    wr(8'h04, 8'h01);
    tick(1);
    check("R4 go0 no stop", vid_code, 31);
    wr(8'h04, 8'h81);
    tick(1);
    check("R5 retarget", vid_code, 32);
    tick(8);
    check("R5 reached", vid_code, 40);
    @(negedge clk);
    check("R5 busy drop", ramp_busy, 0);

    // R4 GO at target
    wr(8'h04, 8'h81);
    check("R4 eq busy", ramp_busy, 1);
    @(negedge clk);
    check("R4 eq drop", ramp_busy, 0);
    check("R4 eq vid", vid_code, 40);

    // R6 command registers
    wr(8'h03, 8'h03);
    wr(8'h05, 8'h02);
    check("R6 en", ch_en, 3'b011);
    check("R6 ccm", ccm_mode, 3'b101);
    rd(8'h03, 3, "R6 cmd1");
    rd(8'h05, 2, "R6 cmd3");

    // R7 status
    pg_in = 3'b101;
    wr(8'h01, 8'd41);
    wr(8'h04, 8'h81);
    rd(8'h06, 8'h0D, "R7 busy");
    tick(1);
    @(negedge clk);
    rd(8'h06, 8'h05, "R7 idle");
    wr(8'h06, 8'hFF);
    rd(8'h06, 8'h05, "R7 wr ignored");

    // R8 unimplemented addresses
    wr(8'h02, 8'hFF);
    wr(8'h07, 8'hFF);
    wr(8'h00, 8'hFF);
    rd(8'h02, 0, "R8 rd02");
    rd(8'h07, 0, "R8 rd07");
    rd(8'h80, 0, "R8 rd80");
    check("R8 en", ch_en, 3'b011);
    check("R8 vid", vid_code, 41);
    rd(8'h01, 41, "R8 stage");

    // R9 serial bus absent
    bus_off = 1'b1;
    en_pin = 3'b110;
    @(negedge clk);
    check("R9 en", ch_en, 3'b110);
    check("R9 ccm", ccm_mode, 0);
    check("R9 extfb", ext_fb, 1);
    rd(8'h03, 0, "R9 rd");
    wr(8'h03, 8'h00);
    wr(8'h01, 8'd5);
    wr(8'h04, 8'h80);
    tick(2);
    check("R9 vid", vid_code, 41);
    bus_off = 1'b0;
    @(negedge clk);
    check("R9 back en", ch_en, 3'b011);
    rd(8'h03, 3, "R9 cmd kept");
    rd(8'h01, 41, "R9 stage kept");

    // R10 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    @(negedge clk);
    rd(8'h05, 2, "R10 held read");
    for (int k = 0; k < 3; k++) begin
      check("R10 ready low", req_ready, 0);
      check("R10 valid", rsp_valid, 1);
      check("R10 data", rsp_rdata, 2);
      @(negedge clk);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    @(negedge clk);

    // R11 full range
    wr(8'h01, 8'd0);
    wr(8'h04, 8'h81);
    tick(41);
    check("R11 low", vid_code, 0);
    tick(3);
    check("R11 no wrap low", vid_code, 0);
    wr(8'h01, 8'd127);
    wr(8'h04, 8'h81);
    tick(127);
    check("R11 high", vid_code, 127);
    tick(3);
    check("R11 no wrap high", vid_code, 127);
    check("R11 busy", ramp_busy, 0);

    repeat (4) @(negedge clk);
    check("R10 drained", exp_q.size(), 0);
    finish_run();
  end
endmodule